// File: doc/BRIEF.md
# Pipelined Ternary Match Table

The block holds a table of 68-bit ternary entries and compares a 68-bit key against all of them at once. A host starts a search with a command that takes two consecutive clock cycles. The two cycles split the command fields between them. The first cycle picks a global mask pair and supplies three bits for the upper part of the result address. The second cycle picks a comparand pair, which receives a copy of the key, and one of eight result registers, which receives the outcome.

A key bit is compared only where both the global mask and the entry's own local mask are set. The lowest-numbered matching location wins. That location is placed in the low bits of a 22-bit SRAM address, together with the three host bits at the top. The result comes out of a four-stage pipeline. A new search can be accepted every two cycles, so up to two searches are in flight at once.

A maintenance port loads entry values, local masks and global mask registers. Read ports expose the result registers and the comparand registers.

Top module: `tcam_search`

## Requirements
- R1: A search is accepted only when `cmd_vld` is high in two consecutive cycles and `cmd[1:0]` equals 2'b10 in both of them. A first cycle is always paired with the cycle that follows it.
- R2: In the first cycle, `cmd[5:3]` selects global mask pair p, `cmd[8:6]` supplies the upper address bits, and `cmd[2]` must be 0.
- R3: In the second cycle, `cmd[5:2]` selects comparand pair c and `cmd[8:6]` selects result register r.
- R4: An accepted key is written to comparand registers 2c (even) and 2c+1 (odd), readable on `cmp_data` through `cmp_sel`.
- R5: Key bit i of an entry takes part in the compare only when bit i of global mask register 2p is 1 and bit i of that entry's local mask is 1. A 0 in either mask makes the bit don't-care.
- R6: When several entries match, the lowest location wins. An entry that has never been written never matches.
- R7: On a hit, `sram_addr` is {upper bits, zeros, location}, with the location in bits [LOC_W-1:0] and the host bits in [21:19]. On a miss, `sram_addr` is 0.
- R8: Result register r receives hit=1 and the R7 address on a hit, or hit=0 and address 0 on a miss. After reset, all result registers read hit=0 and address 0.
- R9: If the second command cycle is sampled in cycle n, `srch_vld` is high for exactly cycle n+4, and `srch_hit` is high in that cycle only on a match.
- R10: Back-to-back searches, with no idle cycle between them, are all accepted. Their results appear two cycles apart, in issue order.
- R11: A bad pair is discarded and updates no comparand or result register, and `cmd_err` pulses high for one cycle in cycle n+1. A bad pair is one with a wrong code in either cycle, `cmd[2]`=1 in the first cycle, keys that differ between the cycles, or `cmd_vld` low in the second cycle.
- R12: A maintenance write (`mnt_we`=1) acts according to `mnt_sel`. The value 0 writes the entry value at location `mnt_addr` and marks that entry valid. The value 1 writes that entry's local mask. The value 2 writes global mask register `mnt_addr[3:0]`, where register 2p+m is member m of pair p. The value 3 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld | input | 1 | Command word valid |
| cmd | input | 9 | Command word |
| cmd_data | input | 68 | Search key |
| mnt_we | input | 1 | Maintenance write strobe |
| mnt_sel | input | 2 | Maintenance target |
| mnt_addr | input | MA_W (6) | Maintenance location or register index |
| mnt_data | input | 68 | Maintenance write value |
| rslt_sel | input | 3 | Result register read select |
| rslt_hit | output | 1 | Selected result register hit flag |
| rslt_addr | output | 22 | Selected result register address |
| cmp_sel | input | 5 | Comparand register read select |
| cmp_data | output | 68 | Selected comparand register |
| sram_addr | output | 22 | Search result address |
| srch_vld | output | 1 | Search result strobe |
| srch_hit | output | 1 | Search found a match |
| cmd_err | output | 1 | Discarded command pulse |

## Verification
Because the pipeline is four stages deep and a search can be issued every two cycles, a result can leave the pipeline in the same cycle that the decoder accepts or rejects a new pair. Two kinds of write can then coincide: the comparand write or error pulse of the new pair, and the result register write of the earlier search. The bench issues three searches back to back, all aimed at one result register, and follows them at once with a malformed pair. A scoreboard then matches each `srch_vld` pulse to its expected cycle, hit flag and address. The result register and the comparand registers are read afterwards, to confirm that only the last accepted search took effect and that the rejected pair left no trace.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int KEY_W    = 68;
  localparam int SADR_W   = 22;
  localparam int UP_W     = 3;
  localparam int GSEL_W   = 3;
  localparam int CSEL_W   = 4;
  localparam int RSEL_W   = 3;
  localparam int N_GMR    = 2 ** (GSEL_W + 1);
  localparam int N_CMP    = 2 ** (CSEL_W + 1);
  localparam int N_RSLT   = 2 ** RSEL_W;
  localparam logic [1:0] OP_SEARCH = 2'b10;

  typedef enum logic [1:0] {
    MNT_VALUE = 2'd0,
    MNT_LMASK = 2'd1,
    MNT_GMASK = 2'd2,
    MNT_NONE  = 2'd3
  } mnt_sel_e;
endpackage

// File: rtl/tcam_cmd_dec.sv
module tcam_cmd_dec
  import tcam_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [8:0]        cmd,
  input  logic [KEY_W-1:0]  cmd_data,
  output logic              acc,
  output logic              err,
  output logic [GSEL_W-1:0] gsel,
  output logic [UP_W-1:0]   up,
  output logic [CSEL_W-1:0] csel,
  output logic [RSEL_W-1:0] rsel,
  output logic [KEY_W-1:0]  key
);
  logic              have_a_q, have_a_d;
  logic              a_ok_q;
  logic [GSEL_W-1:0] a_gsel_q;
  logic [UP_W-1:0]   a_up_q;
  logic [KEY_W-1:0]  a_key_q;
  logic              acc_d, err_d;
  logic              cap_a;

  assign cap_a = cmd_vld && !have_a_q;

  always_comb begin
    have_a_d = have_a_q;
    acc_d    = 1'b0;
    err_d    = 1'b0;
    if (have_a_q) begin
      have_a_d = 1'b0;
      if (cmd_vld && a_ok_q && (cmd[1:0] == OP_SEARCH) && (cmd_data == a_key_q))
        acc_d = 1'b1;
      else
        err_d = 1'b1;
    end else if (cmd_vld) begin
      have_a_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_a_q <= 1'b0;
      a_ok_q   <= 1'b0;
      acc      <= 1'b0;
      err      <= 1'b0;
    end else begin
      have_a_q <= have_a_d;
      acc      <= acc_d;
      err      <= err_d;
      if (cap_a) a_ok_q <= (cmd[1:0] == OP_SEARCH) && !cmd[2];
    end
  end

  always_ff @(posedge clk) begin
    if (cap_a) begin
      a_gsel_q <= cmd[5:3];
      a_up_q   <= cmd[8:6];
      a_key_q  <= cmd_data;
    end
    if (acc_d) begin
      gsel <= a_gsel_q;
      up   <= a_up_q;
      csel <= cmd[5:2];
      rsel <= cmd[8:6];
      key  <= a_key_q;
    end
  end
endmodule

// File: rtl/tcam_array.sv
module tcam_array
  import tcam_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int MA_W  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_sel,
  input  logic [MA_W-1:0]  wr_addr,
  input  logic [KEY_W-1:0] wr_data,
  input  logic             cmp_en,
  input  logic [KEY_W-1:0] key,
  input  logic [KEY_W-1:0] gmask,
  output logic [DEPTH-1:0] match
);
  logic [DEPTH-1:0] hit_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic             vld_q;
    logic [KEY_W-1:0] val_q;
    logic [KEY_W-1:0] lm_q;
    logic             sel;

    assign sel = wr_en && (wr_addr == MA_W'(g));
    assign hit_d[g] = vld_q && (((key ^ val_q) & gmask & lm_q) == '0);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= 1'b0;
      else if (sel && (wr_sel == MNT_VALUE)) vld_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel && (wr_sel == MNT_VALUE)) val_q <= wr_data;
      if (sel && (wr_sel == MNT_LMASK)) lm_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (cmp_en) match <= hit_d;
  end
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
  parameter int DEPTH = 64,
  parameter int LOC_W = 6
) (
  input  logic [DEPTH-1:0] vec,
  output logic             any,
  output logic [LOC_W-1:0] loc
);
  always_comb begin
    any = |vec;
    loc = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (vec[i]) loc = LOC_W'(i);
    end
  end
endmodule

// File: rtl/tcam_search.sv
module tcam_search
  import tcam_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int LOC_W = $clog2(DEPTH),
  parameter int MA_W  = (LOC_W > 4) ? LOC_W : 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [8:0]        cmd,
  input  logic [KEY_W-1:0]  cmd_data,
  input  logic              mnt_we,
  input  logic [1:0]        mnt_sel,
  input  logic [MA_W-1:0]   mnt_addr,
  input  logic [KEY_W-1:0]  mnt_data,
  input  logic [2:0]        rslt_sel,
  output logic              rslt_hit,
  output logic [SADR_W-1:0] rslt_addr,
  input  logic [4:0]        cmp_sel,
  output logic [KEY_W-1:0]  cmp_data,
  output logic [SADR_W-1:0] sram_addr,
  output logic              srch_vld,
  output logic              srch_hit,
  output logic              cmd_err
);
  localparam int PAD_W = SADR_W - UP_W - LOC_W;

  // reset: asserted asynchronously, released on a clock edge
  logic rst_m_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_m_q    <= 1'b1;
      rst_sync_n <= rst_m_q;
    end
  end

  // stage 1: command decode
  logic              dec_acc;
  logic [GSEL_W-1:0] dec_gsel;
  logic [UP_W-1:0]   dec_up;
  logic [CSEL_W-1:0] dec_csel;
  logic [RSEL_W-1:0] dec_rsel;
  logic [KEY_W-1:0]  dec_key;

  tcam_cmd_dec u_dec (
    .clk(clk), .rst_n(rst_sync_n), .cmd_vld(cmd_vld), .cmd(cmd),
    .cmd_data(cmd_data), .acc(dec_acc), .err(cmd_err), .gsel(dec_gsel),
    .up(dec_up), .csel(dec_csel), .rsel(dec_rsel), .key(dec_key)
  );

  // global mask register file
  logic [KEY_W-1:0] gmr_q [N_GMR];
  logic             gmr_we;
  logic [KEY_W-1:0] gmask;
  assign gmr_we = mnt_we && (mnt_sel == MNT_GMASK);
  assign gmask  = gmr_q[{dec_gsel, 1'b0}];

  always_ff @(posedge clk) begin
    if (gmr_we) gmr_q[mnt_addr[3:0]] <= mnt_data;
  end

  // comparand register file: even and odd member written together
  logic [KEY_W-1:0] cmp_q [N_CMP];
  always_ff @(posedge clk) begin
    if (dec_acc) begin
      cmp_q[{dec_csel, 1'b0}] <= dec_key;
      cmp_q[{dec_csel, 1'b1}] <= dec_key;
    end
  end
  assign cmp_data = cmp_q[cmp_sel];

  // stage 2: match vector
  logic [DEPTH-1:0]  match;
  logic              s2_vld_q;
  logic [UP_W-1:0]   s2_up_q;
  logic [RSEL_W-1:0] s2_rsel_q;

  tcam_array #(.DEPTH(DEPTH), .MA_W(MA_W)) u_arr (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(mnt_we), .wr_sel(mnt_sel),
    .wr_addr(mnt_addr), .wr_data(mnt_data), .cmp_en(dec_acc),
    .key(dec_key), .gmask(gmask), .match(match)
  );

  // stage 3: priority resolution
  logic              pe_any;
  logic [LOC_W-1:0]  pe_loc;
  logic              s3_vld_q, s3_hit_q;
  logic [LOC_W-1:0]  s3_loc_q;
  logic [UP_W-1:0]   s3_up_q;
  logic [RSEL_W-1:0] s3_rsel_q;

  tcam_prio #(.DEPTH(DEPTH), .LOC_W(LOC_W)) u_prio (
    .vec(match), .any(pe_any), .loc(pe_loc)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s2_vld_q <= 1'b0;
      s3_vld_q <= 1'b0;
    end else begin
      s2_vld_q <= dec_acc;
      s3_vld_q <= s2_vld_q;
    end
  end

  always_ff @(posedge clk) begin
    if (dec_acc) begin
      s2_up_q   <= dec_up;
      s2_rsel_q <= dec_rsel;
    end
    if (s2_vld_q) begin
      s3_hit_q  <= pe_any;
      s3_loc_q  <= pe_loc;
      s3_up_q   <= s2_up_q;
      s3_rsel_q <= s2_rsel_q;
    end
  end

  // stage 4: output and result registers
  logic [SADR_W-1:0] res_addr_d;
  logic              stat_hit_q  [N_RSLT];
  logic [SADR_W-1:0] stat_addr_q [N_RSLT];

  always_comb begin
    if (s3_hit_q) res_addr_d = {s3_up_q, {PAD_W{1'b0}}, s3_loc_q};
    else          res_addr_d = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      srch_vld  <= 1'b0;
      srch_hit  <= 1'b0;
      sram_addr <= '0;
    end else begin
      srch_vld <= s3_vld_q;
      srch_hit <= s3_vld_q && s3_hit_q;
      if (s3_vld_q) sram_addr <= res_addr_d;
    end
  end

  for (genvar r = 0; r < N_RSLT; r++) begin : g_stat
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        stat_hit_q[r]  <= 1'b0;
        stat_addr_q[r] <= '0;
      end else if (s3_vld_q && (s3_rsel_q == RSEL_W'(r))) begin
        stat_hit_q[r]  <= s3_hit_q;
        stat_addr_q[r] <= res_addr_d;
      end
    end
  end

  assign rslt_hit  = stat_hit_q[rslt_sel];
  assign rslt_addr = stat_addr_q[rslt_sel];
endmodule

// File: rtl/tcam_search_chk.sv
module tcam_search_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        dec_acc,
  input logic        cmd_err,
  input logic        srch_vld,
  input logic        srch_hit,
  input logic [21:0] sram_addr
);
  // R9
  vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_vld |=> !srch_vld);
  // R9
  hit_qual_chk: assert property (@(posedge clk) disable iff (!rst_n)
    srch_hit |-> srch_vld);
  // R9
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_acc |-> ##3 srch_vld);
  // R7
  miss_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_vld && !srch_hit) |-> (sram_addr == 22'd0));
  // R10
  accept_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_acc |=> !dec_acc);
  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err |=> !cmd_err);
  // R11
  err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_err, dec_acc}));
endmodule

bind tcam_search tcam_search_chk u_chk (
  .clk(clk), .rst_n(rst_sync_n), .dec_acc(dec_acc), .cmd_err(cmd_err),
  .srch_vld(srch_vld), .srch_hit(srch_hit), .sram_addr(sram_addr)
);

// File: tb/tcam_search_tb.sv
module tcam_search_tb;
  localparam int KW = 68;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_vld;
  logic [8:0]    cmd;
  logic [KW-1:0] cmd_data;
  logic          mnt_we;
  logic [1:0]    mnt_sel;
  logic [5:0]    mnt_addr;
  logic [KW-1:0] mnt_data;
  logic [2:0]    rslt_sel;
  logic          rslt_hit;
  logic [21:0]   rslt_addr;
  logic [4:0]    cmp_sel;
  logic [KW-1:0] cmp_data;
  logic [21:0]   sram_addr;
  logic          srch_vld, srch_hit, cmd_err;

  always #10 clk = ~clk;

  tcam_search u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd(cmd), .cmd_data(cmd_data),
    .mnt_we(mnt_we), .mnt_sel(mnt_sel), .mnt_addr(mnt_addr), .mnt_data(mnt_data),
    .rslt_sel(rslt_sel), .rslt_hit(rslt_hit), .rslt_addr(rslt_addr),
    .cmp_sel(cmp_sel), .cmp_data(cmp_data), .sram_addr(sram_addr),
    .srch_vld(srch_vld), .srch_hit(srch_hit), .cmd_err(cmd_err)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit mon_on = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // reference model
  logic          m_vld   [64];
  logic [KW-1:0] m_val   [64];
  logic [KW-1:0] m_lm    [64];
  logic [KW-1:0] m_gmr   [16];
  logic [KW-1:0] m_cmp   [32];
  logic          m_shit  [8];
  logic [21:0]   m_saddr [8];

  typedef struct {
    logic        hit;
    logic [21:0] addr;
    int          cyc;
    int          rsel;
    string       req;
  } exp_t;
  exp_t sq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [KW-1:0] act, input logic [KW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on each result strobe
  always @(negedge clk) begin
    if (mon_on) begin
      if (srch_vld) begin
        if (sq.size() == 0) begin
          chk(1'b0, "R9", "unexpected srch_vld", 1, 0);
        end else begin
          exp_t e;
          e = sq.pop_front();
          chk(cyc == e.cyc, e.req, "result cycle", cyc, e.cyc);
          chk(srch_hit === e.hit, e.req, "srch_hit", srch_hit, e.hit);
          chk(sram_addr === e.addr, e.req, "sram_addr", sram_addr, e.addr);
          m_shit[e.rsel]  = e.hit;
          m_saddr[e.rsel] = e.addr;
        end
      end else if (sq.size() != 0 && cyc > sq[0].cyc) begin
        chk(1'b0, "R9", "missing srch_vld", 0, 1);
        void'(sq.pop_front());
      end
    end
  end

  task automatic mwrite(input logic [1:0] sel, input int addr, input logic [KW-1:0] d);
    @(negedge clk);
    mnt_we = 1'b1; mnt_sel = sel; mnt_addr = 6'(addr); mnt_data = d;
    if (sel == 2'd0) begin m_val[addr] = d; m_vld[addr] = 1'b1; end
    if (sel == 2'd1) m_lm[addr] = d;
    if (sel == 2'd2) m_gmr[addr % 16] = d;
    @(negedge clk);
    mnt_we = 1'b0;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cmd_vld = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  // driver: issues a legal search and pushes the expected result
  task automatic search(input logic [KW-1:0] k, input int gs, input logic [2:0] up,
                        input int cs, input int rs, input string req);
    exp_t e;
    int   win;
    win = -1;
    for (int i = 63; i >= 0; i--)
      if (m_vld[i] === 1'b1 && (((k ^ m_val[i]) & m_gmr[2*gs] & m_lm[i]) == '0)) win = i;
    e.hit  = (win >= 0);
    e.addr = e.hit ? {up, 13'd0, 6'(win)} : 22'd0;
    e.rsel = rs;
    e.req  = req;
    @(negedge clk);
    cmd_vld = 1'b1; cmd = {up, 3'(gs), 1'b0, 2'b10}; cmd_data = k;
    @(negedge clk);
    cmd = {3'(rs), 4'(cs), 2'b10};
    e.cyc = cyc + 4;
    sq.push_back(e);
    m_cmp[2*cs]   = k;
    m_cmp[2*cs+1] = k;
  endtask

  // malformed pair: must raise cmd_err one cycle after the second word
  task automatic bad(input logic [8:0] ca, input logic [KW-1:0] ka, input bit vb,
                     input logic [8:0] cb, input logic [KW-1:0] kb, input string what);
    @(negedge clk);
    cmd_vld = 1'b1; cmd = ca; cmd_data = ka;
    @(negedge clk);
    cmd_vld = vb; cmd = cb; cmd_data = kb;
    @(negedge clk);
    cmd_vld = 1'b0;
    chk(cmd_err === 1'b1, "R11", what, cmd_err, 1);
    @(negedge clk);
    chk(cmd_err === 1'b0, "R11", {what, " one-cycle"}, cmd_err, 0);
  endtask

  task automatic chk_stat(input int r, input string req);
    rslt_sel = 3'(r);
    #1;
    chk(rslt_hit === m_shit[r], req, $sformatf("rslt_hit[%0d]", r), rslt_hit, m_shit[r]);
    chk(rslt_addr === m_saddr[r], req, $sformatf("rslt_addr[%0d]", r), rslt_addr, m_saddr[r]);
  endtask

  task automatic chk_cmp(input int i, input string req);
    cmp_sel = 5'(i);
    #1;
    chk(cmp_data === m_cmp[i], req, $sformatf("cmp_data[%0d]", i), cmp_data, m_cmp[i]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  localparam logic [KW-1:0] K1 = 68'hA_0123_4567_89AB_CDEF;
  localparam logic [KW-1:0] K2 = 68'h5_FEDC_BA98_7654_3210;
  localparam logic [KW-1:0] K3 = 68'h3_1357_9BDF_2468_ACE0;
  localparam logic [KW-1:0] K4 = 68'hC_0F0F_0F0F_0F0F_0F0F;

  initial begin
    for (int i = 0; i < 64; i++) m_vld[i] = 1'b0;
    for (int i = 0; i < 8; i++) begin m_shit[i] = 1'b0; m_saddr[i] = '0; end
    rst_n = 1'b0; cmd_vld = 1'b0; cmd = '0; cmd_data = '0;
    mnt_we = 1'b0; mnt_sel = 2'd3; mnt_addr = '0; mnt_data = '0;
    rslt_sel = '0; cmp_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R8 reset state
    chk(srch_vld === 1'b0, "R9", "srch_vld after reset", srch_vld, 0);
    chk(cmd_err === 1'b0, "R11", "cmd_err after reset", cmd_err, 0);
    chk_stat(0, "R8");
    chk_stat(7, "R8");

    // R12 loading: masks, entries
    mwrite(2'd2, 0, '1);
    mwrite(2'd2, 1, '1);
    mwrite(2'd2, 2, ~68'hFF);
    mwrite(2'd2, 3, ~68'hFF);
    mwrite(2'd1, 5, '1);  mwrite(2'd0, 5, K1);
    mwrite(2'd1, 9, '1);  mwrite(2'd0, 9, K1);
    mwrite(2'd1, 3, ~68'hF); mwrite(2'd0, 3, K2);
    mwrite(2'd1, 20, '1); mwrite(2'd0, 20, K3);
    mwrite(2'd1, 40, '1); // local mask only: entry 40 stays invalid
    // R12 select value 3 must not alter entry 3
    @(negedge clk); mnt_we = 1'b1; mnt_sel = 2'd3; mnt_addr = 6'd3; mnt_data = K4;
    @(negedge clk); mnt_we = 1'b0;

    // R6 R7 lowest of two matches, upper bits spliced in
    search(K1, 0, 3'b101, 1, 0, "R6");
    idle(6);
    chk_stat(0, "R8");
    chk_cmp(2, "R4");
    chk_cmp(3, "R4");

    // R5 local mask don't-care on low nibble; R12 entry 3 unaltered by sel 3
    search(K2 ^ 68'h6, 0, 3'b010, 2, 1, "R5");
    idle(6);
    chk_stat(1, "R8");

    // R5 global mask: low byte differs, full mask misses, pair 1 hits
    search(K3 ^ 68'h5A, 0, 3'b111, 3, 2, "R5");
    idle(6);
    chk_stat(2, "R8");
    search(K3 ^ 68'h5A, 1, 3'b111, 3, 2, "R2");
    idle(6);
    chk_stat(2, "R8");

    // R6 no match anywhere, unwritten entries never match
    search(K4, 0, 3'b001, 4, 6, "R6");
    idle(6);
    chk_stat(6, "R8");

    // R3 comparand pair and result register select at top of range
    search(K2, 0, 3'b011, 15, 7, "R3");
    idle(6);
    chk_stat(7, "R3");
    chk_cmp(30, "R3");
    chk_cmp(31, "R4");

    // R1 R10 back-to-back into one result register, then a bad pair while results drain
    search(K1, 0, 3'b100, 6, 5, "R10");
    search(K2 ^ 68'h6, 0, 3'b100, 7, 5, "R10");
    search(K4, 0, 3'b100, 8, 5, "R1");
    bad({3'd0, 3'd0, 1'b0, 2'b11}, K3, 1'b1, {3'd5, 4'd9, 2'b10}, K3, "bad first code");
    idle(6);
    chk_stat(5, "R10");
    chk_cmp(16, "R10");
    chk_cmp(18, "R11");

    // R11 remaining illegal forms: none may touch pair 8 or register 5
    bad({3'd0, 3'd0, 1'b0, 2'b10}, K3, 1'b1, {3'd5, 4'd8, 2'b01}, K3, "bad second code");
    bad({3'd0, 3'd0, 1'b1, 2'b10}, K3, 1'b1, {3'd5, 4'd8, 2'b10}, K3, "bit2 set");
    bad({3'd0, 3'd0, 1'b0, 2'b10}, K3, 1'b1, {3'd5, 4'd8, 2'b10}, K1, "key mismatch");
    bad({3'd0, 3'd0, 1'b0, 2'b10}, K3, 1'b0, {3'd5, 4'd8, 2'b10}, K3, "valid dropped");
    idle(6);
    chk_stat(5, "R11");
    chk_cmp(16, "R11");
    chk(sq.size() == 0, "R9", "scoreboard drained", sq.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule